// File: doc/BRIEF.md
# Redundant Radix-Switching Sequential Divider

This block divides a 16-bit two's-complement dividend by an 8-bit positive divisor and returns a 32-bit quotient with 16 integer and 16 fraction bits. It runs as a multi-cycle unit. A one-cycle `start` pulse captures both operands. The unit then works through a fixed budget of result bits, one step per clock, and pulses `done` with the quotient valid on the same cycle.

Each step reads a four-bit window of the signed partial remainder: its sign bit and the three bits below it. From that window the step either skips one or two quotient positions with a bare shift, or retires two positions with a single add or subtract of twice or three times the divisor. The partial remainder is allowed to go negative, so the quotient digits are redundant and nothing is ever restored. Both divisor multiples are formed once at load time, so a step needs only one full-width adder.

Before the first step, the dividend is halved when it is too large against the divisor, and that halving is folded into the final left shift. The final shift also absorbs any unused bit budget.

Top module: `rdiv_top`

## Requirements
- R1: During and right after reset, `busy` and `done` are 0 and `quotient` is 0.
- R2: At load, the dividend is doubled and the divisor is placed 8 bits up, so the unit position of the 16.16 frame is bit 16. If the doubled dividend is positive and greater than the placed divisor, or negative with magnitude at least the placed divisor, the remainder is halved and the final shift grows by one.
- R3: A window (remainder bits 16..13) of 0000 or 1111 shifts the remainder and quotient left by two. It adds nothing and uses two bits of budget.
- R4: A window of 0001 or 1110 shifts the remainder and quotient left by one and uses one bit of budget.
- R5: Any other window selects twice the divisor in two cases: the window is 0010, 0011 with divisor bit 6 set, 1101, or 1100 with divisor bit 6 set. Otherwise it selects three times the divisor. Either way the remainder and quotient first shift left by two.
- R6: With bit 16 of the remainder clear, the selected multiple is subtracted and the quotient gains 2 (for 2D) or 3 (for 3D). With bit 16 set, the multiple is added and the quotient loses 2 or 3.
- R7: The bit budget is ITER (default 9). At the end, the quotient is shifted left by 23 − ITER, plus one if the halving of R2 occurred, plus the leftover budget. The leftover may be −1, and the total shift never goes below zero.
- R8: Exactly one step is taken per clock after the load edge. `done` rises k cycles after the load edge, where k is the number of steps.
- R9: `busy` stays high from the cycle after the load edge until `done`. `done` lasts exactly one cycle, and `busy` is low while it is high.
- R10: A `start` pulse while `busy` is high is ignored: the running result is unchanged and no second run follows.
- R11: For dividends 16384..32767 and divisors 128..255, the quotient differs from floor(dividend·65536/divisor) by less than 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load operands and begin when idle |
| dividend | input | 16 | Signed dividend |
| divisor | input | 8 | Positive divisor |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 32 | Signed 16.16 quotient, valid with `done` |

## Verification
The bench sweeps the operand grid and adds zero and negative dividends. Together these reach the halving path, both window signs, the bit-6 tie-break between 2D and 3D, and a final step that overshoots the budget.

Each error shows up differently:
- A wrong window slice or case boundary gives the wrong quotient and often a different latency.
- A wrong add/subtract direction makes the remainder diverge, which breaks the accuracy bound.
- A final shift that ignores the −1 leftover is off by a factor of two.
- A unit that accepts `start` while busy either corrupts the running result or produces a second `done`.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    SEL_SKIP2 = 2'd0,
    SEL_SKIP1 = 2'd1,
    SEL_MUL2  = 2'd2,
    SEL_MUL3  = 2'd3
  } step_sel_e;
endpackage

// File: rtl/rdiv_align.sv
// Load-time alignment of operands into the fixed-point frame and range scaling.
module rdiv_align #(
  parameter int DVW   = 16,
  parameter int DW    = 8,
  parameter int FRAC  = 16,
  parameter int RW    = 24,
  parameter int NW    = 6,
  parameter int NBASE = 14
) (
  input  logic [DVW-1:0]       dividend,
  input  logic [DW-1:0]        divisor,
  output logic signed [RW-1:0] rem0,
  output logic signed [RW-1:0] dm2,
  output logic signed [RW-1:0] dm3,
  output logic                 dbit,
  output logic [NW-1:0]        norm0
);
  localparam int DSH = FRAC - DW;

  logic signed [RW-1:0] dnorm;
  logic signed [RW-1:0] r1;
  logic                 over;

  assign dnorm = {{(RW-DW-DSH){1'b0}}, divisor, {DSH{1'b0}}};
  assign r1    = {{(RW-DVW-1){dividend[DVW-1]}}, dividend, 1'b0};

  // R2: magnitude test, strict on the positive side, inclusive on the negative side
  always_comb begin
    if (r1[RW-1]) over = ((-r1) >= dnorm);
    else          over = (r1 > dnorm);
  end

  assign rem0  = over ? (r1 >>> 1) : r1;
  assign dm2   = dnorm <<< 1;
  assign dm3   = dnorm + (dnorm <<< 1);
  assign dbit  = divisor[DW-2];
  assign norm0 = NW'(NBASE) + NW'(over);
endmodule

// File: rtl/rdiv_pick.sv
// Case selection from the four-bit remainder window and divisor bit.
module rdiv_pick
  import rdiv_pkg::*;
(
  input  logic [3:0] win,
  input  logic       dbit,
  output step_sel_e  sel
);
  always_comb begin
    if (win == 4'b0000 || win == 4'b1111)      sel = SEL_SKIP2;   // R3
    else if (win == 4'b0001 || win == 4'b1110) sel = SEL_SKIP1;   // R4
    else if (win < 4'd3 || win > 4'd12)        sel = SEL_MUL2;    // R5
    else if ((win == 4'd3 || win == 4'd12) && dbit) sel = SEL_MUL2;
    else                                       sel = SEL_MUL3;
  end
endmodule

// File: rtl/rdiv_step.sv
// One iteration: shift, optional add/subtract of a divisor multiple, budget update.
module rdiv_step
  import rdiv_pkg::*;
#(
  parameter int RW   = 24,
  parameter int QW   = 32,
  parameter int LW   = 5,
  parameter int FRAC = 16
) (
  input  logic signed [RW-1:0] rem,
  input  logic signed [QW-1:0] q,
  input  logic signed [LW-1:0] left,
  input  step_sel_e            sel,
  input  logic signed [RW-1:0] dm2,
  input  logic signed [RW-1:0] dm3,
  output logic signed [RW-1:0] rem_n,
  output logic signed [QW-1:0] q_n,
  output logic signed [LW-1:0] left_n
);
  logic                 neg;
  logic signed [RW-1:0] mult;
  logic signed [QW-1:0] digit;
  logic signed [RW-1:0] rem_s2;
  logic signed [QW-1:0] q_s2;

  assign neg    = rem[FRAC];
  assign mult   = (sel == SEL_MUL3) ? dm3 : dm2;
  assign digit  = (sel == SEL_MUL3) ? QW'(3) : QW'(2);
  assign rem_s2 = rem <<< 2;
  assign q_s2   = q <<< 2;

  always_comb begin
    rem_n  = rem_s2;
    q_n    = q_s2;
    left_n = left - LW'(2);
    case (sel)
      SEL_SKIP1: begin
        rem_n  = rem <<< 1;
        q_n    = q <<< 1;
        left_n = left - LW'(1);
      end
      SEL_MUL2, SEL_MUL3: begin
        if (neg) begin
          rem_n = rem_s2 + mult;
          q_n   = q_s2 - digit;
        end else begin
          rem_n = rem_s2 - mult;
          q_n   = q_s2 + digit;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int DVW  = 16,
  parameter int DW   = 8,
  parameter int FRAC = 16,
  parameter int ITER = 9,
  parameter int RW   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVW-1:0]   dividend,
  input  logic [DW-1:0]    divisor,
  output logic             busy,
  output logic             done,
  output logic [2*FRAC-1:0] quotient
);
  localparam int QW    = 2 * FRAC;
  localparam int NBASE = QW - DW - 1 - ITER;
  localparam int NW    = $clog2(NBASE + 2) + 1;
  localparam int LW    = $clog2(ITER + 3) + 1;
  localparam int SW    = ((NW > LW) ? NW : LW) + 2;

  logic                 run_q, run_d;
  logic                 done_q, done_d;
  logic signed [RW-1:0] rem_q, rem_d;
  logic signed [QW-1:0] q_q, q_d;
  logic signed [RW-1:0] d2_q, d2_d, d3_q, d3_d;
  logic                 dbit_q, dbit_d;
  logic [NW-1:0]        norm_q, norm_d;
  logic signed [LW-1:0] left_q, left_d;
  logic [QW-1:0]        quo_q, quo_d;

  logic signed [RW-1:0] rem0, dm2, dm3;
  logic                 dbit0;
  logic [NW-1:0]        norm0;
  step_sel_e            sel;
  logic signed [RW-1:0] rem_n;
  logic signed [QW-1:0] q_n;
  logic signed [LW-1:0] left_n;
  logic signed [SW-1:0] sh_raw;
  logic [SW-1:0]        shamt;

  rdiv_align #(.DVW(DVW), .DW(DW), .FRAC(FRAC), .RW(RW), .NW(NW), .NBASE(NBASE)) u_align (
    .dividend(dividend), .divisor(divisor),
    .rem0(rem0), .dm2(dm2), .dm3(dm3), .dbit(dbit0), .norm0(norm0)
  );

  rdiv_pick u_pick (
    .win(rem_q[FRAC -: 4]), .dbit(dbit_q), .sel(sel)
  );

  rdiv_step #(.RW(RW), .QW(QW), .LW(LW), .FRAC(FRAC)) u_step (
    .rem(rem_q), .q(q_q), .left(left_q), .sel(sel), .dm2(d2_q), .dm3(d3_q),
    .rem_n(rem_n), .q_n(q_n), .left_n(left_n)
  );

  // R7: final shift = normalisation count plus leftover budget, floored at zero
  assign sh_raw = $signed({{(SW-NW){1'b0}}, norm_q}) + $signed({{(SW-LW){left_n[LW-1]}}, left_n});
  assign shamt  = sh_raw[SW-1] ? '0 : sh_raw;

  always_comb begin
    run_d  = run_q;
    done_d = 1'b0;
    rem_d  = rem_q;
    q_d    = q_q;
    d2_d   = d2_q;
    d3_d   = d3_q;
    dbit_d = dbit_q;
    norm_d = norm_q;
    left_d = left_q;
    quo_d  = quo_q;
    if (!run_q) begin
      if (start) begin
        run_d  = 1'b1;
        rem_d  = rem0;
        q_d    = '0;
        d2_d   = dm2;
        d3_d   = dm3;
        dbit_d = dbit0;
        norm_d = norm0;
        left_d = LW'(ITER);
      end
    end else begin
      rem_d  = rem_n;
      q_d    = q_n;
      left_d = left_n;
      if (left_n <= 0) begin
        run_d  = 1'b0;
        done_d = 1'b1;
        quo_d  = q_n <<< shamt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      q_q    <= '0;
      d2_q   <= '0;
      d3_q   <= '0;
      dbit_q <= 1'b0;
      norm_q <= '0;
      left_q <= '0;
      quo_q  <= '0;
    end else begin
      run_q  <= run_d;
      done_q <= done_d;
      rem_q  <= rem_d;
      q_q    <= q_d;
      d2_q   <= d2_d;
      d3_q   <= d3_d;
      dbit_q <= dbit_d;
      norm_q <= norm_d;
      left_q <= left_d;
      quo_q  <= quo_d;
    end
  end

  assign busy     = run_q;
  assign done     = done_q;
  assign quotient = quo_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);  // R9
  AST_NOT_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);  // R9
  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(d2_q) && $stable(d3_q) && $stable(norm_q)));  // R10
  AST_BUDGET_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (left_q + LW'(1) == $past(left_q) || left_q + LW'(2) == $past(left_q)));  // R8
  AST_SKIP2_ZERO_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel == SEL_SKIP2) |=> (q_q[1:0] == 2'b00));  // R3
  AST_SKIP1_ZERO_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel == SEL_SKIP1) |=> (q_q[0] == 1'b0));  // R4
  AST_MUL3_POS_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel == SEL_MUL3 && !rem_q[FRAC]) |=> (q_q[1:0] == 2'b11));  // R6
  AST_MUL3_NEG_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel == SEL_MUL3 && rem_q[FRAC]) |=> (q_q[1:0] == 2'b01));  // R6
endmodule

// File: tb/rdiv_top_bench.sv
module rdiv_top_bench;
  localparam int ITER = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [7:0]  divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;

  int errors = 0;
  int checks = 0;
  int n_s2 = 0, n_s1 = 0, n_m2 = 0, n_m3 = 0, n_tie2 = 0, n_tie3 = 0;
  int n_negadd = 0, n_half = 0, n_over = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdiv_top #(.ITER(ITER)) u_rdiv_top (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference of the stepping rules, in plain integers
  task automatic model(input int dvd, input int dvs, output int q, output int steps);
    int r, d, d2, d3, n, i, t, k, sh;
    bit db;
    d = dvs << 8; db = d[14]; d2 = 2 * d; d3 = 3 * d;
    r = dvd * 2; n = 23 - ITER;
    if ((r > 0 && r > d) || (r < 0 && -r >= d)) begin r = r / 2; n++; n_half++; end
    q = 0; i = ITER; steps = 0;
    while (i > 0) begin
      t = (r >>> 13) & 15;
      steps++;
      if (t == 0 || t == 15) begin r = r <<< 2; q = q <<< 2; i -= 2; n_s2++; end
      else if (t == 1 || t == 14) begin r = r <<< 1; q = q <<< 1; i -= 1; n_s1++; end
      else begin
        if (t < 3 || t > 12 || ((t == 3 || t == 12) && db)) begin
          k = 2; n_m2++; if (t == 3 || t == 12) n_tie2++;
        end else begin
          k = 3; n_m3++; if (t == 3 || t == 12) n_tie3++;
        end
        r = r <<< 2; q = q <<< 2; i -= 2;
        if ((t & 8) == 0) begin r -= (k == 3) ? d3 : d2; q += k; end
        else begin r += (k == 3) ? d3 : d2; q -= k; n_negadd++; end
      end
    end
    if (i < 0) n_over++;
    sh = n + i; if (sh < 0) sh = 0;
    q = q <<< sh;
  endtask

  task automatic run_one(input int dvd, input int dvs, input bit disturb);
    int eq, esteps, lat;
    longint exact, diff;
    model(dvd, dvs, eq, esteps);
    @(negedge clk);
    dividend = dvd[15:0]; divisor = dvs[7:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    check(busy == 1'b1, "R9 busy after load", longint'(busy), 1);
    while (!done && lat < 64) begin
      if (!busy) check(1'b0, "R9 busy held until done", longint'(busy), 1);
      if (disturb && lat == 2) begin
        start = 1'b1; dividend = 16'h1234; divisor = 8'd131;   // R10: start while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done seen", longint'(done), 1);
    check(busy == 1'b0, "R9 busy low with done", longint'(busy), 0);
    // R2 R3 R4 R5 R6 R7: quotient matches the stepping rules
    check($signed(quotient) == eq, "R2 R3 R4 R5 R6 R7 quotient", longint'($signed(quotient)), longint'(eq));
    check(lat == esteps, "R8 latency", longint'(lat), longint'(esteps));
    if (dvd >= 16384 && dvd <= 32767 && dvs >= 128 && dvs <= 255) begin
      exact = (longint'(dvd) * 65536) / dvs;
      diff = exact - longint'($signed(quotient));
      if (diff < 0) diff = -diff;
      check(diff < 65536, "R11 accuracy", longint'($signed(quotient)), exact);
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", longint'(done), 0);
    if (disturb)
      check(busy == 1'b0, "R10 no second run", longint'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R1 done in reset", longint'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(quotient == 32'd0, "R1 quotient after reset", longint'(quotient), 0);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", longint'(busy), 0);

    run_one(16384, 128, 1'b0);
    run_one(32767, 255, 1'b0);
    run_one(32767, 128, 1'b0);
    run_one(16384, 255, 1'b0);
    run_one(0, 200, 1'b0);
    run_one(-16384, 128, 1'b0);
    run_one(-1, 255, 1'b0);
    run_one(-32768, 200, 1'b0);
    run_one(20000, 170, 1'b1);
    run_one(30000, 129, 1'b1);
    for (int a = 0; a < 64; a++)
      for (int b = 0; b < 32; b++)
        run_one(16384 + a * 257, 128 + b * 4 + (b % 4), 1'b0);
    for (int b = 0; b < 32; b++)
      run_one(32767, 128 + b * 4, 1'b0);

    check(n_s2 > 0, "R3 coverage", n_s2, 1);
    check(n_s1 > 0, "R4 coverage", n_s1, 1);
    check(n_tie2 > 0 && n_tie3 > 0, "R5 tie-break coverage", n_tie2, 1);
    check(n_negadd > 0 && n_m2 > 0 && n_m3 > 0, "R6 coverage", n_negadd, 1);
    check(n_half > 0, "R2 coverage", n_half, 1);
    check(n_over > 0, "R7 overshoot coverage", n_over, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule